// File: doc/BRIEF.md
# Receive Pad and FCS Stripper

This block sits in a receive byte stream directly behind the MAC. It counts the bytes of each frame and reads the 16-bit length/type field that occupies stream bytes 12 and 13. When stripping is enabled and that field is a length below 46, only the 14 header bytes and the number of payload bytes given by the field are forwarded. The padding and the trailing 4-byte frame check sequence are consumed without producing any output. In every other case the frame is forwarded byte for byte, with its check sequence kept.

Both sides use a valid/ready byte stream with an end-of-frame flag. A single output register gives one cycle of latency and honours backpressure. The stripping enable is taken from the first byte of each frame, so a change in the middle of a frame never splits that frame's treatment. A separate combinational flag reports the forbidden case in which stripping and receive checksum offload are both enabled.

Top module: `rx_pad_stripper`

## Requirements
- R1: With stripping captured as enabled and a length field L below 46 (field read big-endian, byte 12 high, byte 13 low), exactly the first 14 + L bytes of the frame are forwarded and all later bytes (pad and 4-byte FCS) are discarded.
- R2: On a stripped frame, the end-of-frame flag is raised on the last kept byte (byte 13 when L is 0), no other forwarded byte of that frame carries it, and the remaining input bytes are accepted without any output.
- R3: A length field of 46 or more, including every type value of 1536 and above, leaves the frame unchanged, FCS included.
- R4: With stripping disabled, every frame passes unchanged. The enable is sampled on the first byte of each frame, and a change later in the frame has no effect on that frame.
- R5: The conflict output is high exactly when the stripping enable and the checksum-offload enable inputs are both high.
- R6: A frame that ends before its last kept byte is reached, including one shorter than 14 bytes, is forwarded unchanged with its own end-of-frame flag.
- R7: While output valid is high and output ready is low, the output byte and its end-of-frame flag hold steady. Input ready is high only when the output register is empty or being drained, and no byte is lost or duplicated.
- R8: A byte accepted at a clock edge appears at the output right after that edge.
- R9: After reset the output is not valid and input ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strip_en | input | 1 | Enables pad and FCS removal |
| csum_en | input | 1 | Receive checksum-offload enable, used only for the conflict flag |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can take an input byte |
| in_data | input | DATA_W | Input byte |
| in_last | input | 1 | Input byte ends the frame |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream takes the output byte |
| out_data | output | DATA_W | Output byte |
| out_last | output | 1 | Output byte ends the frame |
| conflict | output | 1 | Both enables set |

## Verification
The bench uses the default parameters: 8-bit bytes, the length field at byte 12, a 46-byte minimum payload and an 8-bit saturating byte counter. With these values, the full range of short lengths (0, 1, 20, 45) and the boundary value 46 fit in ordinary 64-byte frames. A 1518-byte frame drives the counter into saturation, so the bench shows that long frames and the frames after them are unaffected. Pseudo-random input gaps and output stalls make frame ends, including dropped tails, coincide with backpressure.

// File: rtl/rxps_pkg.sv
package rxps_pkg;

    // Frame-handling phase of the byte tracker
    typedef enum logic [1:0] {
        PH_PASS = 2'd0,  // header, or frame forwarded as is
        PH_KEEP = 2'd1,  // short frame, still inside kept payload
        PH_DROP = 2'd2   // short frame, discarding pad and FCS
    } phase_e;

endpackage

// File: rtl/rxps_len_decode.sv
module rxps_len_decode #(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned CNT_W       = 8,
    parameter int unsigned LEN_POS     = 12,
    parameter int unsigned MIN_PAYLOAD = 46
) (
    input  logic             en,
    input  logic [DATA_W-1:0] len_hi,
    input  logic [DATA_W-1:0] len_lo,
    output logic             strip,
    output logic [CNT_W-1:0] last_idx
);
    localparam int unsigned LEN_W = 2 * DATA_W;
    localparam int unsigned SUM_W = LEN_W + 1;

    logic [LEN_W-1:0] len_val;
    logic [SUM_W-1:0] sum;

    always_comb begin
        len_val  = {len_hi, len_lo};
        strip    = en && (len_val < LEN_W'(MIN_PAYLOAD));
        // index of final kept byte: header end (LEN_POS+1) plus payload count
        sum      = SUM_W'(LEN_POS + 1) + SUM_W'(len_val);
        last_idx = sum[CNT_W-1:0];
    end
endmodule

// File: rtl/rxps_out_stage.sv
module rxps_out_stage #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              ld_last,
    input  logic              dn_ready,
    output logic              can_load,
    output logic              dn_valid,
    output logic [DATA_W-1:0] dn_data,
    output logic              dn_last
);
    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
        logic              last;
    } slot_t;

    slot_t o_d, o_q;

    always_comb begin
        o_d      = o_q;
        can_load = !o_q.valid || dn_ready;
        if (o_q.valid && dn_ready) begin
            o_d.valid = 1'b0;
        end
        if (load) begin
            o_d.valid = 1'b1;
            o_d.data  = ld_data;
            o_d.last  = ld_last;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign dn_valid = o_q.valid;
    assign dn_data  = o_q.data;
    assign dn_last  = o_q.last;
endmodule

// File: rtl/rx_pad_stripper.sv
module rx_pad_stripper #(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned CNT_W       = 8,
    parameter int unsigned LEN_POS     = 12,
    parameter int unsigned MIN_PAYLOAD = 46
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strip_en,
    input  logic              csum_en,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last,
    output logic              conflict
);
    import rxps_pkg::*;

    localparam logic [CNT_W-1:0] HI_IDX  = CNT_W'(LEN_POS);
    localparam logic [CNT_W-1:0] LO_IDX  = CNT_W'(LEN_POS + 1);
    localparam logic [CNT_W-1:0] IDX_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0]  idx;
        logic [CNT_W-1:0]  keep_last;
        logic [DATA_W-1:0] len_hi;
        logic              en_cap;
        phase_e            phase;
    } trk_t;

    trk_t st_d, st_q;

    logic             accept;
    logic             emit;
    logic             emit_last;
    logic             dec_strip;
    logic [CNT_W-1:0] dec_last;
    logic             drop_active;

    rxps_len_decode #(
        .DATA_W      (DATA_W),
        .CNT_W       (CNT_W),
        .LEN_POS     (LEN_POS),
        .MIN_PAYLOAD (MIN_PAYLOAD)
    ) i_len_decode (
        .en       (st_q.en_cap),
        .len_hi   (st_q.len_hi),
        .len_lo   (in_data),
        .strip    (dec_strip),
        .last_idx (dec_last)
    );

    assign accept = in_valid && in_ready;

    always_comb begin
        st_d      = st_q;
        emit      = 1'b0;
        emit_last = in_last;
        if (accept) begin
            emit = (st_q.phase != PH_DROP);
            if (st_q.idx == '0) begin
                st_d.en_cap = strip_en;
            end
            if (st_q.idx == HI_IDX) begin
                st_d.len_hi = in_data;
            end
            if (st_q.phase == PH_PASS && st_q.idx == LO_IDX && dec_strip) begin
                if (dec_last == st_q.idx) begin
                    emit_last  = 1'b1;
                    st_d.phase = PH_DROP;
                end else begin
                    st_d.keep_last = dec_last;
                    st_d.phase     = PH_KEEP;
                end
            end else if (st_q.phase == PH_KEEP && st_q.idx == st_q.keep_last) begin
                emit_last  = 1'b1;
                st_d.phase = PH_DROP;
            end
            if (in_last) begin
                st_d.idx   = '0;
                st_d.phase = PH_PASS;
            end else if (st_q.idx != IDX_MAX) begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= '0;
            st_q.phase <= PH_PASS;
        end else begin
            st_q <= st_d;
        end
    end

    rxps_out_stage #(
        .DATA_W (DATA_W)
    ) i_out_stage (
        .clk      (clk),
        .rst      (rst),
        .load     (emit),
        .ld_data  (in_data),
        .ld_last  (emit_last),
        .dn_ready (out_ready),
        .can_load (in_ready),
        .dn_valid (out_valid),
        .dn_data  (out_data),
        .dn_last  (out_last)
    );

    assign drop_active = (st_q.phase == PH_DROP);
    assign conflict    = strip_en && csum_en;
endmodule

// File: rtl/rxps_checker.sv
module rxps_checker #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic              out_last,
    input logic              drop_active
);
    // R7: a stalled output byte stays put
    a_r7_hold_stable: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

    // R8: a freshly valid output byte comes from the input accepted one edge earlier
    a_r8_source: assert property (@(posedge clk) disable iff (rst)
        out_valid && !$past(out_valid && !out_ready) |-> $past(in_valid && in_ready));

    // R2: bytes consumed while discarding the tail never reach the output
    a_r2_drop_silent: assert property (@(posedge clk) disable iff (rst)
        drop_active && !(out_valid && !out_ready) |=> !out_valid);

    // R9: output empty on the first cycle out of reset
    a_r9_reset_empty: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid && in_ready);
endmodule

bind rx_pad_stripper rxps_checker #(
    .DATA_W (DATA_W)
) i_rxps_checker (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_data    (out_data),
    .out_last    (out_last),
    .drop_active (drop_active)
);

// File: tb/test_rx_pad_stripper.sv
module test_rx_pad_stripper;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       strip_en = 1'b0;
    logic       csum_en = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = '0;
    logic       in_last = 1'b0;
    logic       out_valid;
    logic       out_ready = 1'b1;
    logic [7:0] out_data;
    logic       out_last;
    logic       conflict;

    int n_checks = 0;
    int n_fail = 0;
    bit bp_on = 1'b0;
    bit gaps_on = 1'b0;
    logic [15:0] lfsr_r = 16'hACE1;
    logic [15:0] lfsr_g = 16'h1D2B;

    logic [8:0] exp_q[$];
    string      exp_req[$];

    always #10 clk = ~clk;

    rx_pad_stripper i_rx_pad_stripper (
        .clk(clk), .rst(rst), .strip_en(strip_en), .csum_en(csum_en),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_last(out_last), .conflict(conflict)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Output ready pattern
    initial forever begin
        @(negedge clk);
        lfsr_r = {lfsr_r[14:0], lfsr_r[15] ^ lfsr_r[13] ^ lfsr_r[12] ^ lfsr_r[10]};
        out_ready = bp_on ? (lfsr_r[0] | lfsr_r[3]) : 1'b1;
    end

    // Reference comparison on every clock
    bit         held = 1'b0;
    logic [8:0] held_val;
    initial forever begin
        @(negedge clk);
        #5;
        if (!rst) begin
            if (held) begin
                check(out_valid && {out_last, out_data} == held_val, "R7 hold",
                      {out_valid, out_last, out_data}, {1'b1, held_val});
            end
            held = out_valid && !out_ready;
            held_val = {out_last, out_data};
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R1 extra output byte", {out_last, out_data}, 0);
                end else begin
                    automatic logic [8:0] e = exp_q.pop_front();
                    automatic string r = exp_req.pop_front();
                    check({out_last, out_data} == e, r, {out_last, out_data}, e);
                end
            end
        end
    end

    task automatic send_frame(input int len_field, input int pay, input int cut,
                              input bit en, input bit flip, input string req);
        logic [7:0] frm[$];
        int total, keep;
        total = 14 + pay + 4;
        if (cut > 0) total = cut;
        for (int i = 0; i < total; i++) begin
            if (i == 12) frm.push_back(8'(len_field >> 8));
            else if (i == 13) frm.push_back(8'(len_field));
            else frm.push_back(8'(i * 37 + len_field + 5));
        end
        keep = total;
        if (en && total >= 14 && len_field < 46 && 14 + len_field < total)
            keep = 14 + len_field;
        for (int i = 0; i < keep; i++) begin
            exp_q.push_back({i == keep - 1, frm[i]});
            exp_req.push_back(req);
        end
        @(negedge clk);
        strip_en = en;
        for (int i = 0; i < total; i++) begin
            forever begin
                @(negedge clk);
                lfsr_g = {lfsr_g[14:0], lfsr_g[15] ^ lfsr_g[13] ^ lfsr_g[12] ^ lfsr_g[10]};
                if (gaps_on && lfsr_g[0] && lfsr_g[2]) begin
                    in_valid = 1'b0;
                end else begin
                    in_valid = 1'b1;
                    in_data = frm[i];
                    in_last = (i == total - 1);
                    #5;
                    if (in_ready) begin
                        @(posedge clk);
                        #1;
                        if (i == 0 && flip) strip_en = !en;
                        break;
                    end
                end
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last = 1'b0;
    endtask

    task automatic drain();
        for (int k = 0; k < 400 && exp_q.size() != 0; k++) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #5;
        check(!out_valid, "R9 out_valid after reset", out_valid, 0);
        check(in_ready, "R9 in_ready after reset", in_ready, 1);

        // R5 conflict flag, all four combinations
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            strip_en = c[0];
            csum_en = c[1];
            #2;
            check(conflict == (c == 3), "R5 conflict", conflict, c == 3);
        end
        csum_en = 1'b0;

        // R8 latency: a one-byte frame appears right after its edge (also R6)
        @(negedge clk);
        strip_en = 1'b1;
        exp_q.push_back({1'b1, 8'hA5});
        exp_req.push_back("R6 one-byte frame");
        in_valid = 1'b1; in_data = 8'hA5; in_last = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        #5;
        check(out_valid && out_data == 8'hA5 && out_last, "R8 latency",
              {out_valid, out_last, out_data}, {2'b11, 8'hA5});
        drain();

        // Stripping of short frames (R1, R2)
        send_frame(0, 46, 0, 1'b1, 1'b0, "R2 L=0 last on byte 13");
        send_frame(1, 46, 0, 1'b1, 1'b0, "R1 L=1");
        send_frame(20, 46, 0, 1'b1, 1'b0, "R1 L=20");
        send_frame(45, 46, 0, 1'b1, 1'b0, "R1 L=45");
        drain();
        // Unchanged frames (R3, R4)
        send_frame(46, 46, 0, 1'b1, 1'b0, "R3 L=46 boundary");
        send_frame(1500, 1500, 0, 1'b1, 1'b0, "R3 L=1500 counter saturation");
        send_frame(16'h0800, 46, 0, 1'b1, 1'b0, "R3 type value");
        send_frame(10, 46, 0, 1'b0, 1'b0, "R4 disabled");
        drain();
        // Enable changes after first byte: treatment fixed at frame start (R4)
        send_frame(10, 46, 0, 1'b1, 1'b1, "R4 enable dropped mid-frame");
        send_frame(10, 46, 0, 1'b0, 1'b1, "R4 enable raised mid-frame");
        // Early-ending frames (R6)
        send_frame(30, 46, 34, 1'b1, 1'b0, "R6 frame ends in payload");
        send_frame(5, 46, 10, 1'b1, 1'b0, "R6 frame shorter than header");
        send_frame(5, 46, 19, 1'b1, 1'b0, "R6 frame ends on last kept byte");
        drain();

        // Backpressure and input gaps (R7)
        bp_on = 1'b1;
        gaps_on = 1'b1;
        for (int k = 0; k < 6; k++) begin
            send_frame(k * 9, 46, 0, 1'b1, 1'b0, "R7 short frame under stalls");
            send_frame(60 + k, 60 + k, 0, 1'b1, 1'b0, "R7 long frame under stalls");
        end
        send_frame(3, 46, 0, 1'b1, 1'b0, "R2 tail dropped under stalls");
        drain();
        bp_on = 1'b0;
        gaps_on = 1'b0;
        drain();
        check(exp_q.size() == 0, "R7 all expected bytes delivered", exp_q.size(), 0);
        check(!out_valid, "R2 no output after dropped tail", out_valid, 0);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R7 watchdog expired", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule